// File: doc/BRIEF.md
# Packet-Aware Transmit Byte FIFO

This block sits between firmware and a byte-serial transmitter. Firmware pushes bytes on a write port into 128 bytes of storage. After a start strobe, a sequencer presents the stored bytes to a downstream consumer over a valid/ready handshake. It closes the packet according to one of three length policies, chosen when the packet starts:

- **Fixed:** a byte count taken from a length input.
- **Variable:** a count carried in the first byte of the packet.
- **Endless:** the stream runs until firmware flushes.

Packets may be longer than the storage, provided firmware refills while the packet drains. Firmware tracks the block through a status word, a live occupancy count and a threshold level output. The threshold level output falls when occupancy drops below the programmed level, which tells firmware when to refill. A flush strobe discards everything and returns the block to idle.

Top module: `txpkt_fifo_engine`

## Requirements
- R1: The block stores up to 128 bytes. `byte_count` always equals the number of stored bytes (0 to 128, so 0x80 when full). Bytes reach `out_data` in the order they were written. A write is stored only when the FIFO is not full.
- R2: `status[3]` (full) is high exactly when 128 bytes are stored.
- R3: `status[2]` and `thr_level` are high exactly when `byte_count >= tx_thresh`. For example, with a threshold of 7 and a partial fill of 7 or more bytes, the status reads 0x04.
- R4: Fixed mode (`len_mode` = 0) hands exactly `pkt_len` bytes to the consumer after `start`. If `pkt_len` = 0, the packet ends at once without sending a byte.
- R5: Variable mode (`len_mode` = 1) first hands over the length byte L, then exactly L further bytes; `pkt_len` has no effect. If L = 0, the packet ends after the length byte.
- R6: Endless mode (`len_mode` = 2 or 3) keeps `out_valid` high whenever bytes are stored. It never ends by itself; only a flush returns it to idle.
- R7: A `flush` empties the FIFO, clears both sticky flags and aborts any packet. A write in the same cycle is dropped.
- R8: A write while full sets the sticky overflow flag `status[0]` and leaves the content unchanged.
- R9: Underflow: a fixed or variable packet is running, the FIFO is empty, and no write arrives in that cycle. The block then sets the sticky underflow flag `status[1]` and returns to idle without `done`.
- R10: `status[4]` (busy) is high while a packet runs, and `start` is ignored while busy. `done` pulses for one cycle, in the cycle after the handshake of a fixed or variable packet's last byte, or after a start with `pkt_len` = 0 in fixed mode. `status[7:5]` read 0.
- R11: `out_valid` is high only while busy, with data stored and bytes still owed. `out_data` and `out_valid` hold while the consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push one byte |
| wr_data | input | 8 | Byte to push |
| flush | input | 1 | Discard content, clear sticky flags, abort packet |
| start | input | 1 | Begin a packet (ignored while busy) |
| len_mode | input | 2 | 0 fixed, 1 variable, 2 or 3 endless |
| pkt_len | input | 8 | Byte count for fixed mode, sampled at start |
| tx_thresh | input | 8 | Threshold level for the threshold flag |
| out_valid | output | 1 | Byte offered downstream |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Byte offered downstream |
| status | output | 8 | {3'b0, busy, full, thresh, underflow, overflow} |
| byte_count | output | 8 | Current occupancy |
| thr_level | output | 1 | High while occupancy is at or above the threshold |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
Two events can fall in the same cycle: a refill write and the underflow decision. A write can arrive in exactly the cycle the running packet finds the FIFO empty. A flush can also coincide with a write, with a start or with the last handshake of a packet. The bench provokes these collisions directly, with a one-byte prefill plus a refill write on every cycle, and also through dense random traffic. A cycle-level reference model computes the expected outcome: the write rescues the packet, and a flush always wins. It compares every output on every cycle.

// File: rtl/txpkt_pkg.sv
// Shared types for the packet-aware transmit FIFO.
package txpkt_pkg;
    // Length policy selected at packet start; both upper codes mean endless.
    typedef enum logic [1:0] {
        LM_FIXED   = 2'd0,
        LM_VARLEN  = 2'd1,
        LM_ENDLESS = 2'd2,
        LM_ENDALT  = 2'd3
    } len_mode_e;

    // Status word bit positions (firmware decodes these).
    localparam int ST_OVF  = 0;
    localparam int ST_UDF  = 1;
    localparam int ST_THR  = 2;
    localparam int ST_FULL = 3;
    localparam int ST_BUSY = 4;
endpackage

// File: rtl/txpkt_store.sv
// Byte storage with first-word-fall-through head and occupancy counter.
// Assumes: pop is only requested when not empty; flush beats push and pop.
module txpkt_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          push_ok,
    output logic          ovf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_req && !full && !flush;
    assign ovf_evt = push_req && full && !flush;
    assign head    = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the array on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Maintain pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop)     rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop && !flush) |=> (count == $past(count))); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R7
endmodule

// File: rtl/txpkt_flags.sv
// Level flags from occupancy plus sticky overflow/underflow bits.
// Assumes: count is registered; flush clears the sticky bits.
module txpkt_flags #(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thresh,
    input  logic          ovf_evt,
    input  logic          udf_evt,
    output logic          thr_hit,
    output logic          ovf_sticky,
    output logic          udf_sticky
);
    assign thr_hit = (count >= thresh);

    // Hold error events until firmware flushes.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovf_sticky <= 1'b0;
            udf_sticky <= 1'b0;
        end else begin
            if (ovf_evt) ovf_sticky <= 1'b1;
            if (udf_evt) udf_sticky <= 1'b1;
        end
    end

    AST_OVF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !flush) |=> ovf_sticky); // R8
endmodule

// File: rtl/txpkt_seq.sv
// Packet sequencer: gates the handshake and decides end of packet.
// Assumes: head is valid whenever empty is low; mode and length are latched at start.
module txpkt_seq
    import txpkt_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          start,
    input  logic [1:0]    mode_in,
    input  logic [LW-1:0] len_in,
    input  logic          empty,
    input  logic [DW-1:0] head,
    input  logic          push_ok,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          pop,
    output logic          busy,
    output logic          done,
    output logic          udf_evt
);
    len_mode_e     mode_q;
    logic [LW-1:0] remain_q;
    logic          need_len_q;
    logic          endless;
    logic          owed;

    assign endless   = mode_q[1];
    assign owed      = need_len_q || endless || (remain_q != '0);
    assign out_valid = busy && !empty && owed;
    assign pop       = out_valid && out_ready;
    assign udf_evt   = busy && !endless && empty && !push_ok && !flush;

    // Track packet progress and raise the end-of-packet pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            mode_q     <= LM_FIXED;
            remain_q   <= '0;
            need_len_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (flush || udf_evt) begin
                busy <= 1'b0;
            end else if (pop) begin
                if (need_len_q) begin
                    need_len_q <= 1'b0;
                    remain_q   <= LW'(head);
                    if (head == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else if (!endless) begin
                    remain_q <= remain_q - 1'b1;
                    if (remain_q == LW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else if (!busy && start) begin
                mode_q     <= len_mode_e'(mode_in);
                remain_q   <= len_in;
                need_len_q <= (mode_in == LM_VARLEN);
                if (mode_in == LM_FIXED && len_in == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !empty); // R11
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(head))); // R11
    AST_UDF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> (!busy && !done)); // R9
endmodule

// File: rtl/txpkt_fifo_engine.sv
// Top: transmit FIFO with packet-length policies and status reporting.
// Assumes: firmware keeps tx_thresh at or below DEPTH; len_mode/pkt_len matter only at start.
module txpkt_fifo_engine
    import txpkt_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int LW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          flush,
    input  logic          start,
    input  logic [1:0]    len_mode,
    input  logic [LW-1:0] pkt_len,
    input  logic [CW-1:0] tx_thresh,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [7:0]    status,
    output logic [CW-1:0] byte_count,
    output logic          thr_level,
    output logic          done
);
    logic          pop, empty, full, push_ok, ovf_evt, udf_evt;
    logic          thr_hit, ovf_sticky, udf_sticky, busy;
    logic [DW-1:0] head;

    txpkt_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_req(wr_en), .push_data(wr_data), .pop(pop),
        .head(head), .count(byte_count), .empty(empty), .full(full),
        .push_ok(push_ok), .ovf_evt(ovf_evt)
    );

    txpkt_flags #(.DEPTH(DEPTH)) flags_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .count(byte_count), .thresh(tx_thresh),
        .ovf_evt(ovf_evt), .udf_evt(udf_evt),
        .thr_hit(thr_hit), .ovf_sticky(ovf_sticky), .udf_sticky(udf_sticky)
    );

    txpkt_seq #(.DW(DW), .LW(LW)) seq_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
        .mode_in(len_mode), .len_in(pkt_len),
        .empty(empty), .head(head), .push_ok(push_ok), .out_ready(out_ready),
        .out_valid(out_valid), .pop(pop), .busy(busy), .done(done),
        .udf_evt(udf_evt)
    );

    assign out_data  = head;
    assign thr_level = thr_hit;

    // Assemble the firmware-visible status word.
    always_comb begin
        status          = '0;
        status[ST_OVF]  = ovf_sticky;
        status[ST_UDF]  = udf_sticky;
        status[ST_THR]  = thr_hit;
        status[ST_FULL] = full;
        status[ST_BUSY] = busy;
    end

    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_FULL] |-> (byte_count == CW'(DEPTH))); // R2
    AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> status[ST_BUSY]); // R11
endmodule

// File: tb/txpkt_fifo_engine_tb_top.sv
// Self-checking bench: cycle-level reference model, directed corners, then seeded random traffic.
module txpkt_fifo_engine_tb_top;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, flush = 0, start = 0, out_ready = 0;
    logic [7:0] wr_data = 0, pkt_len = 0, tx_thresh = 8'd7;
    logic [1:0] len_mode = 0;
    logic       out_valid, done, thr_level;
    logic [7:0] out_data, status, byte_count;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    logic [7:0] q_m[$];
    bit         run_m = 0, need_m = 0, ovf_m = 0, udf_m = 0, done_m = 0;
    logic [1:0] mode_m = 0;
    int         remain_m = 0;

    always #4 clk = ~clk;  // 125 MHz

    txpkt_fifo_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flush(flush), .start(start), .len_mode(len_mode), .pkt_len(pkt_len),
        .tx_thresh(tx_thresh), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .status(status), .byte_count(byte_count),
        .thr_level(thr_level), .done(done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_valid();
        return run_m && q_m.size() > 0 && (mode_m[1] || need_m || remain_m != 0);
    endfunction

    function automatic string mode_tag();
        return (mode_m == 2'd0) ? "R4" : (mode_m == 2'd1) ? "R5" : "R6";
    endfunction

    // Compare every output against the model.
    task automatic compare();
        bit ev = exp_valid();
        chk("R11", "out_valid", out_valid, ev);
        if (ev && out_valid) chk(mode_tag(), "out_data", out_data, q_m[0]);
        chk("R1", "byte_count", byte_count, q_m.size());
        chk("R2", "full", status[3], q_m.size() == DEPTH);
        chk("R3", "thresh", status[2], q_m.size() >= tx_thresh);
        chk("R3", "thr_level", thr_level, q_m.size() >= tx_thresh);
        chk("R8", "overflow", status[0], ovf_m);
        chk("R9", "underflow", status[1], udf_m);
        chk("R10", "busy", status[4], run_m);
        chk("R10", "done", done, done_m);
        chk("R10", "status_hi", status[7:5], 0);
    endtask

    // Advance the model by one clock using the inputs that were stable before the edge.
    function automatic void model_step();
        bit was_run = run_m;
        bit pop = exp_valid() && out_ready;
        bit push = wr_en && q_m.size() < DEPTH;
        done_m = 0;
        if (flush) begin
            q_m.delete(); ovf_m = 0; udf_m = 0; run_m = 0;
            return;
        end
        if (wr_en && q_m.size() == DEPTH) ovf_m = 1;
        if (run_m && !mode_m[1] && q_m.size() == 0 && !push) begin
            udf_m = 1; run_m = 0;
        end
        if (pop) begin
            logic [7:0] b = q_m.pop_front();
            if (need_m) begin
                need_m = 0; remain_m = b;
                if (b == 0) begin run_m = 0; done_m = 1; end
            end else if (!mode_m[1]) begin
                remain_m--;
                if (remain_m == 0) begin run_m = 0; done_m = 1; end
            end
        end
        if (push) q_m.push_back(wr_data);
        if (!was_run && start) begin
            mode_m = len_mode; remain_m = pkt_len; need_m = (len_mode == 2'd1);
            if (len_mode == 2'd0 && pkt_len == 0) done_m = 1;
            else run_m = 1;
        end
    endfunction

    task automatic step();
        #1;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en = 0; flush = 0; start = 0; out_ready = 0;
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            idle_inputs(); wr_en = 1; wr_data = base + 8'(i); step();
        end
        idle_inputs();
    endtask

    task automatic do_flush();
        idle_inputs(); flush = 1; step(); idle_inputs();
    endtask

    task automatic run_ready(input int n);
        for (int i = 0; i < n; i++) begin
            idle_inputs(); out_ready = 1; step();
        end
        idle_inputs();
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Reset state
        chk("R1", "reset count", byte_count, 0);
        chk("R10", "reset status", status, 8'h00);
        step();

        // Fill past full: threshold at 7, full at 128, overflow beyond (R2 R3 R8)
        tx_thresh = 8'd7;
        push_bytes(6, 8'h10);
        chk("R3", "below thr", thr_level, 0);
        push_bytes(1, 8'h16);
        chk("R3", "status at thr", status, 8'h04);
        push_bytes(121, 8'h17);
        chk("R2", "full status", status, 8'h0C);
        chk("R1", "full count", byte_count, 8'h80);
        push_bytes(2, 8'hEE);
        chk("R8", "overflow status", status, 8'h0D);

        // Flush with a simultaneous write (R7)
        idle_inputs(); flush = 1; wr_en = 1; wr_data = 8'h55; step(); idle_inputs();
        chk("R7", "flush count", byte_count, 0);
        chk("R7", "flush status", status, 8'h00);

        // Fixed packet of 10 from 12 stored (R4)
        push_bytes(12, 8'h40);
        len_mode = 2'd0; pkt_len = 8'd10; start = 1; step(); start = 0;
        run_ready(14);
        chk("R4", "fixed leftover", byte_count, 2);
        chk("R10", "fixed idle", status[4], 0);

        // Zero-length fixed packet ends at once (R4)
        len_mode = 2'd0; pkt_len = 8'd0; start = 1; step(); start = 0;
        chk("R4", "zero len done", done, 1);
        step();
        do_flush();

        // Variable packet: length 3, then three bytes, two extra left (R5)
        idle_inputs(); wr_en = 1; wr_data = 8'd3; step();
        push_bytes(5, 8'hA0);
        len_mode = 2'd1; pkt_len = 8'd99; start = 1; step(); start = 0;
        run_ready(8);
        chk("R5", "var leftover", byte_count, 2);
        do_flush();

        // Endless stream with refill, then flush stops it (R6)
        push_bytes(5, 8'h70);
        len_mode = 2'd2; start = 1; step(); start = 0;
        for (int i = 0; i < 40; i++) begin
            idle_inputs(); out_ready = 1; wr_en = (i % 2 == 0); wr_data = 8'(i); step();
        end
        idle_inputs(); step();
        chk("R6", "endless busy", status[4], 1);
        do_flush();
        chk("R6", "endless stopped", status[4], 0);

        // Underflow: fixed 20 with only 4 stored (R9)
        push_bytes(4, 8'h90);
        len_mode = 2'd0; pkt_len = 8'd20; start = 1; step(); start = 0;
        run_ready(8);
        chk("R9", "underflow flag", status[1], 1);
        do_flush();

        // Refill arriving in the cycle the FIFO empties rescues the packet (R9)
        push_bytes(1, 8'hC0);
        len_mode = 2'd0; pkt_len = 8'd6; start = 1; step(); start = 0;
        for (int i = 0; i < 8; i++) begin
            idle_inputs(); out_ready = 1; wr_en = 1; wr_data = 8'hC1 + 8'(i); step();
        end
        idle_inputs();
        chk("R9", "rescued no underflow", status[1], 0);
        do_flush();

        // Start while busy is ignored (R10)
        push_bytes(3, 8'h20);
        len_mode = 2'd0; pkt_len = 8'd3; start = 1; step();
        len_mode = 2'd2; start = 1; out_ready = 1; step();
        run_ready(4);
        chk("R10", "restart ignored", status[4], 0);
        do_flush();

        // Seeded random traffic
        for (int c = 0; c < 6000; c++) begin
            wr_en     = ($urandom % 100) < 55;
            wr_data   = 8'($urandom);
            out_ready = ($urandom % 100) < 65;
            start     = ($urandom % 100) < 6;
            flush     = ($urandom % 1000) < 8;
            len_mode  = 2'($urandom);
            pkt_len   = 8'($urandom % 48);
            if ($urandom % 200 == 0) tx_thresh = 8'($urandom % 129);
            step();
        end
        idle_inputs(); step();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule